// File: doc/BRIEF.md
# Packed Fingerprint Stream Unpacker

This block accepts a stream of fixed-width bit fingerprints that have been packed densely onto a narrower bus. A fingerprint may begin at any bit of a bus word and may span word boundaries. For each fingerprint, the block emits two aligned bus-width sub-words. The head sub-word carries the low BUS_W bits. The tail sub-word carries the remaining VEC_W-BUS_W bits, zero-padded at the top. Both sub-words carry the sequence number of the fingerprint within the stream.

Incoming words are appended to a bit buffer that holds three bus words. Slices are taken from the bottom of the buffer. A two-state segment controller alternates between head and tail slices. It releases a slice only once enough bits are buffered. The input ready signal drops whenever one more word might not fit in the buffer, so the block throttles its own input without losing data. The parameters must satisfy BUS_W < VEC_W <= 2*BUS_W.

Top module: `fp_stream_unpacker`

## Requirements
- R1: After a synchronous active-high reset, out_valid is 0 and in_ready is 1. The first fingerprint emitted after reset carries ID 0.
- R2: Stream bit k is bit (k mod BUS_W) of input word k/BUS_W. Fingerprint n occupies stream bits n*VEC_W to n*VEC_W+VEC_W-1, with its bit 0 first. Its head sub-word equals fingerprint bits [BUS_W-1:0].
- R3: The tail sub-word has fingerprint bits [VEC_W-1:BUS_W] in its bits [VEC_W-BUS_W-1:0]. All bits above those are 0.
- R4: Sub-words leave in stream order, head then tail, for every fingerprint. No fingerprint is skipped or repeated.
- R5: Both sub-words of fingerprint n carry out_id = n mod 2^ID_W. The ID advances by exactly one after each tail.
- R6: A word is consumed only in a cycle where in_valid and in_ready are both 1. Data presented with in_valid low has no effect on the output sequence.
- R7: in_ready is 0 whenever the buffer holds more than BUF_W-BUS_W bits. The buffer never overflows, so a stream driven with in_valid held high still unpacks correctly.
- R8: out_valid rises only for a complete slice. After reset, a single accepted word of BUS_W bits produces exactly one head sub-word and no tail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_word | input | BUS_W | Packed stream word |
| in_valid | input | 1 | in_word holds data |
| in_ready | output | 1 | Block accepts a word this cycle |
| out_word | output | BUS_W | Aligned sub-word, tail zero-padded |
| out_valid | output | 1 | out_word and out_id are valid |
| out_id | output | ID_W | Sequence number of the fingerprint |

## Verification
A wrong fill count or a wrong segment state shifts every later slice. The first sub-word emitted after the fault therefore shows misaligned bits, usually within one or two fingerprints, and the error persists from then on. A lost or duplicated input word shows up in the same way: the next tail carries bits that belong to the following fingerprint. The ID counter is checked on every sub-word, so a missed or extra increment is visible on the very next output. A lost word is also caught by the final output count.

// File: rtl/fpu_pkg.sv
package fpu_pkg;
  typedef enum logic {
    SEG_HEAD = 1'b0,
    SEG_TAIL = 1'b1
  } seg_e;
endpackage

// File: rtl/fpu_bit_buffer.sv
// Bit accumulator: valid bits sit at the bottom, new words are appended above.
module fpu_bit_buffer #(
  parameter int unsigned BUS_W = 8,
  parameter int unsigned BUF_W = 24,
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [BUS_W-1:0] in_word,
  input  logic             in_valid,
  input  logic [CNT_W-1:0] drop_bits,
  output logic             in_ready,
  output logic [CNT_W-1:0] fill,
  output logic [BUS_W-1:0] window
);
  localparam int unsigned READ_LIMIT = BUF_W - BUS_W;

  logic [BUF_W-1:0] buf_q, kept, incoming;
  logic [CNT_W-1:0] fill_q, fill_left;
  logic             take;

  assign in_ready  = (fill_q <= CNT_W'(READ_LIMIT));
  assign take      = in_valid & in_ready;
  assign kept      = buf_q >> drop_bits;
  assign fill_left = fill_q - drop_bits;
  assign incoming  = {{(BUF_W-BUS_W){1'b0}}, in_word} << fill_left;
  assign fill      = fill_q;
  assign window    = buf_q[BUS_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      buf_q  <= '0;
      fill_q <= '0;
    end else begin
      buf_q  <= take ? (kept | incoming) : kept;
      fill_q <= fill_left + (take ? CNT_W'(BUS_W) : CNT_W'(0));
    end
  end

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    fill_q <= CNT_W'(BUF_W));

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!in_ready) |=> (fill_q <= $past(fill_q)));

  // R2
  clean_upper_chk: assert property (@(posedge clk) disable iff (rst)
    (buf_q >> fill_q) == '0);

  // R8
  drop_le_fill_chk: assert property (@(posedge clk) disable iff (rst)
    drop_bits <= fill_q);
endmodule

// File: rtl/fpu_seg_ctrl.sv
// Chooses head or tail slice, releases it when enough bits are buffered.
module fpu_seg_ctrl
  import fpu_pkg::*;
#(
  parameter int unsigned BUS_W = 8,
  parameter int unsigned VEC_W = 13,
  parameter int unsigned ID_W  = 8,
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] fill,
  output logic [CNT_W-1:0] drop_bits,
  output logic             emit,
  output seg_e             seg,
  output logic [ID_W-1:0]  id
);
  localparam int unsigned TAIL_W = VEC_W - BUS_W;

  seg_e            seg_q;
  logic [ID_W-1:0] id_q;
  logic [CNT_W-1:0] need;

  assign need      = (seg_q == SEG_HEAD) ? CNT_W'(BUS_W) : CNT_W'(TAIL_W);
  assign emit      = (fill >= need);
  assign drop_bits = emit ? need : '0;
  assign seg       = seg_q;
  assign id        = id_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      seg_q <= SEG_HEAD;
      id_q  <= '0;
    end else if (emit) begin
      seg_q <= (seg_q == SEG_HEAD) ? SEG_TAIL : SEG_HEAD;
      if (seg_q == SEG_TAIL) id_q <= id_q + ID_W'(1);
    end
  end

  // R4
  seg_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    emit |=> (seg_q != $past(seg_q)));

  // R5
  id_step_chk: assert property (@(posedge clk) disable iff (rst)
    (emit && seg_q == SEG_TAIL) |=> (id_q == $past(id_q) + ID_W'(1)));

  // R5
  id_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(emit && seg_q == SEG_TAIL) |=> $stable(id_q));
endmodule

// File: rtl/fpu_out_stage.sv
// Registered output: masks tail slices and latches the ID.
module fpu_out_stage
  import fpu_pkg::*;
#(
  parameter int unsigned BUS_W = 8,
  parameter int unsigned VEC_W = 13,
  parameter int unsigned ID_W  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             emit,
  input  seg_e             seg,
  input  logic [BUS_W-1:0] window,
  input  logic [ID_W-1:0]  id,
  output logic [BUS_W-1:0] out_word,
  output logic             out_valid,
  output logic [ID_W-1:0]  out_id
);
  localparam int unsigned TAIL_W = VEC_W - BUS_W;
  localparam logic [BUS_W-1:0] TAIL_MASK = {BUS_W{1'b1}} >> (BUS_W - TAIL_W);

  logic tail_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_word  <= '0;
      out_valid <= 1'b0;
      out_id    <= '0;
      tail_q    <= 1'b0;
    end else begin
      out_valid <= emit;
      if (emit) begin
        out_word <= (seg == SEG_TAIL) ? (window & TAIL_MASK) : window;
        out_id   <= id;
        tail_q   <= (seg == SEG_TAIL);
      end
    end
  end

  // R3
  pad_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && tail_q) |-> ((out_word >> TAIL_W) == '0));

  // R5
  id_pair_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && tail_q && $past(out_valid)) |-> (out_id == $past(out_id)));
endmodule

// File: rtl/fp_stream_unpacker.sv
module fp_stream_unpacker
  import fpu_pkg::*;
#(
  parameter int unsigned BUS_W = 8,
  parameter int unsigned VEC_W = 13,
  parameter int unsigned ID_W  = 8,
  parameter int unsigned BUF_W = 3 * BUS_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [BUS_W-1:0] in_word,
  input  logic             in_valid,
  output logic             in_ready,
  output logic [BUS_W-1:0] out_word,
  output logic             out_valid,
  output logic [ID_W-1:0]  out_id
);
  localparam int unsigned CNT_W = $clog2(BUF_W + 1);

  logic [CNT_W-1:0] fill, drop_bits;
  logic [BUS_W-1:0] window;
  logic             emit;
  seg_e             seg;
  logic [ID_W-1:0]  id;

  fpu_bit_buffer #(.BUS_W(BUS_W), .BUF_W(BUF_W), .CNT_W(CNT_W)) u_buffer (
    .clk(clk), .rst(rst), .in_word(in_word), .in_valid(in_valid),
    .drop_bits(drop_bits), .in_ready(in_ready), .fill(fill), .window(window)
  );

  fpu_seg_ctrl #(.BUS_W(BUS_W), .VEC_W(VEC_W), .ID_W(ID_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst(rst), .fill(fill), .drop_bits(drop_bits),
    .emit(emit), .seg(seg), .id(id)
  );

  fpu_out_stage #(.BUS_W(BUS_W), .VEC_W(VEC_W), .ID_W(ID_W)) u_out (
    .clk(clk), .rst(rst), .emit(emit), .seg(seg), .window(window), .id(id),
    .out_word(out_word), .out_valid(out_valid), .out_id(out_id)
  );
endmodule

// File: tb/test_fp_stream_unpacker.sv
module test_fp_stream_unpacker;
  localparam int CLK_PERIOD = 10;
  localparam int BUS_W   = 8;
  localparam int VEC_W   = 13;
  localparam int ID_W    = 8;
  localparam int N_FP    = 16;
  localparam int N_WORDS = N_FP * VEC_W / BUS_W;
  localparam logic [VEC_W-1:0] FP_TABLE [N_FP] = '{
    13'h1A5B, 13'h0F3C, 13'h1FFF, 13'h0000, 13'h1234, 13'h0ABC, 13'h1001, 13'h07E1,
    13'h1555, 13'h0AAA, 13'h1C3F, 13'h03C0, 13'h1E0F, 13'h0101, 13'h1F80, 13'h0E7D};

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [BUS_W-1:0] in_word = '0;
  logic             in_valid = 1'b0;
  logic             in_ready;
  logic [BUS_W-1:0] out_word;
  logic             out_valid;
  logic [ID_W-1:0]  out_id;

  logic [N_FP*VEC_W-1:0] stream;
  logic [15:0] lfsr = 16'hACE1;
  int n_checks = 0, n_fails = 0, obs_idx = 0, stalls = 0, cycles = 0;

  fp_stream_unpacker #(.BUS_W(BUS_W), .VEC_W(VEC_W), .ID_W(ID_W)) i_fp_stream_unpacker (
    .clk(clk), .rst(rst), .in_word(in_word), .in_valid(in_valid), .in_ready(in_ready),
    .out_word(out_word), .out_valid(out_valid), .out_id(out_id)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
  endtask

  // Output monitor: sub-word k belongs to fingerprint k/2, head when k is even.
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      logic [VEC_W-1:0] fp;
      logic [BUS_W-1:0] exp_w;
      fp = FP_TABLE[(obs_idx / 2) % N_FP];
      if (obs_idx % 2 == 0) begin
        exp_w = fp[BUS_W-1:0];
        check(out_word == exp_w, "R2 head", int'(out_word), int'(exp_w));
      end else begin
        exp_w = BUS_W'(fp >> BUS_W);
        check(out_word == exp_w, "R3 tail", int'(out_word), int'(exp_w));
      end
      check(out_id == ID_W'(obs_idx / 2), "R5 id", int'(out_id), (obs_idx / 2) % (1 << ID_W));
      obs_idx++;
    end
    if (!rst && in_valid && !in_ready) stalls++;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles >= 20000) begin
      n_fails++;
      $display("FAIL R4 watchdog: actual %0d cycles expected fewer", cycles);
      summary();
      $finish;
    end
  end

  task automatic send_word(input int j, input int gap);
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_word  = BUS_W'(8'h5A ^ j[7:0] ^ g[7:0]);
    end
    @(negedge clk);
    in_valid = 1'b1;
    in_word  = stream[j*BUS_W +: BUS_W];
    while (!in_ready) @(negedge clk);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    in_valid = 1'b0;
    in_word  = 8'hC3;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    for (int n = 0; n < N_FP; n++) stream[n*VEC_W +: VEC_W] = FP_TABLE[n];
    repeat (3) @(negedge clk);
    // R1: during reset
    check(out_valid == 1'b0, "R1 valid in reset", int'(out_valid), 0);
    check(in_ready == 1'b1, "R1 ready in reset", int'(in_ready), 1);
    rst = 1'b0;
    obs_idx = 0;
    @(negedge clk);
    check(out_valid == 1'b0, "R1 valid after reset", int'(out_valid), 0);
    check(in_ready == 1'b1, "R1 ready after reset", int'(in_ready), 1);

    // Pass 1: table walk with pseudo-random gaps carrying garbage (R6)
    for (int j = 0; j < N_WORDS; j++) begin
      int gap;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      gap = (lfsr[1:0] == 2'b00) ? int'(lfsr[3:2]) + 1 : 0;
      send_word(j, gap);
    end
    idle(20);
    check(obs_idx == 2 * N_FP, "R4 count pass1", obs_idx, 2 * N_FP);

    // Pass 2: valid held high, internal backpressure (R7)
    stalls = 0;
    for (int j = 0; j < N_WORDS; j++) send_word(j, 0);
    idle(20);
    check(obs_idx == 4 * N_FP, "R4 count pass2", obs_idx, 4 * N_FP);
    check(stalls > 0, "R7 ready dropped", stalls, 1);

    // Directed: reset, garbage with valid low, then a single word (R6, R8, R1)
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    obs_idx = 0;
    for (int g = 0; g < 5; g++) begin
      in_valid = 1'b0;
      in_word  = BUS_W'(8'hF0 + g);
      @(negedge clk);
    end
    check(obs_idx == 0, "R6 no output from idle data", obs_idx, 0);
    send_word(0, 0);
    idle(6);
    check(obs_idx == 1, "R8 single head only", obs_idx, 1);
    check(in_ready == 1'b1, "R8 ready after partial", int'(in_ready), 1);

    summary();
    $finish;
  end
endmodule